// File: doc/BRIEF.md
# Conditional Branch and Skip Unit

This block settles program-flow decisions for a small 8-bit core whose program counter counts 16-bit words. Each request carries the current word address, the status byte, an operation code, a signed 7-bit offset, a 3-bit bit index, a byte taken from a register or an I/O location, two bytes for an equality compare, and the opcode word that follows the current instruction. One clock later the unit presents the address of the next instruction to fetch, the number of cycles the current instruction costs, and whether the decision went the non-sequential way.

Two instruction families are covered. Conditional relative branches test one status bit, chosen by the index, for set or for clear. Skip instructions test one bit of a byte for clear or set, or test two bytes for equality. A skip that holds steps over the following instruction, so its result depends on whether that instruction is one word or two. The unit works out that length itself from the encoding of the following opcode.

Top module: `flow_branch_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `taken`, `next_pc` and `cycles` are all zero.
- R2: A request presented with `req_valid` high at a rising edge produces `out_valid` high for exactly the following cycle. With `req_valid` low, `out_valid` is low on the next cycle whatever the other inputs are.
- R3: Operation code 0 branches when status bit `bit_sel` is 1. Operation code 1 branches when that bit is 0. Bit 0 is carry, bit 1 zero, bit 2 negative, bit 3 overflow, bit 4 sign.
- R4: The sign bit (index 4) is taken as negative XOR overflow (bit 2 XOR bit 3), whatever value bit 4 of `sreg` holds. So branch-if-clear on index 4 is a signed greater-or-equal test, and branch-if-set on index 4 is a signed less-than test.
- R5: A taken branch gives `next_pc` = `pc` + sign-extended `offset` + 1, modulo 2^PC_W, with `cycles` = 2 and `taken` = 1. The offset spans -64 to +63.
- R6: A branch that is not taken gives `next_pc` = `pc` + 1, `cycles` = 1 and `taken` = 0.
- R7: Operation code 2 skips when bit `bit_sel` of `bit_src` is 0. Operation code 3 skips when that bit is 1.
- R8: Operation code 4 skips when `cmp_a` equals `cmp_b`.
- R9: A skip that holds gives `taken` = 1. With a one-word next instruction it gives `next_pc` = `pc` + 2 and `cycles` = 2. With a two-word next instruction it gives `next_pc` = `pc` + 3 and `cycles` = 3. Both wrap modulo 2^PC_W.
- R10: The next instruction is two words exactly when `next_opcode` matches either of two patterns, with x meaning any value. The first pattern is 1001010x_xxxx11xx (direct jump or direct call). The second is 100100xx_xxxx0000 (direct load or direct store).
- R11: A skip that does not hold gives `next_pc` = `pc` + 1, `cycles` = 1 and `taken` = 0, whatever the length of the next instruction.
- R12: Operation codes 5, 6 and 7 give `next_pc` = `pc` + 1, `cycles` = 1 and `taken` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A decision request is present this cycle |
| req_op | input | 3 | Operation code: 0 branch if set, 1 branch if clear, 2 skip if bit clear, 3 skip if bit set, 4 skip if equal |
| pc | input | PC_W (16) | Word address of the current instruction |
| sreg | input | 8 | Status byte |
| offset | input | OFF_W (7) | Signed branch displacement in words |
| bit_sel | input | 3 | Index of the bit under test |
| bit_src | input | 8 | Register or I/O byte for the bit skips |
| cmp_a | input | 8 | First operand of the equality skip |
| cmp_b | input | 8 | Second operand of the equality skip |
| next_opcode | input | 16 | Opcode word that follows the current instruction |
| out_valid | output | 1 | Result fields below are valid |
| next_pc | output | PC_W (16) | Word address to fetch next |
| cycles | output | 2 | Cycles the current instruction costs (1 to 3) |
| taken | output | 1 | The branch was taken or the skip held |

## Verification
The assertions assume that a result on the outputs belongs to the request held on the inputs one edge earlier. They also assume that the operation code, program counter and offset are stable across that edge. The bench drives each request half a period before the capturing edge and leaves it unchanged until it has sampled the result. The operation codes above 4 are driven on purpose, and R12 defines what happens for them. The sweeps cover every status byte and tested byte under every bit index, every opcode whose top nibble is 9 (the region holding all the two-word patterns), and a strided sample of the rest. Directed cases cover wrap-around at both ends of the address space.

// File: rtl/flow_branch_pkg.sv
package flow_branch_pkg;

    localparam int unsigned INSN_W   = 16;
    localparam int unsigned STAT_W   = 8;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned CYC_W    = 2;

    // status bit positions the condition logic depends on
    localparam int unsigned NEG_IDX  = 2;
    localparam int unsigned OVF_IDX  = 3;
    localparam int unsigned SIGN_IDX = 4;

    typedef enum logic [SEL_W-1:0] {
        OPC_BR_IF_SET   = 3'd0,
        OPC_BR_IF_CLR   = 3'd1,
        OPC_SKIP_IF_CLR = 3'd2,
        OPC_SKIP_IF_SET = 3'd3,
        OPC_SKIP_IF_EQ  = 3'd4
    } flow_op_e;

    typedef logic [CYC_W-1:0] cyc_t;

    typedef struct packed {
        logic is_branch;
        logic is_skip;
        logic hit;
    } cond_t;

    // a following opcode that carries a second (address) word
    function automatic logic is_long_opcode(input logic [INSN_W-1:0] w);
        logic jmp_call;
        logic ld_st_direct;
        jmp_call     = (w & 16'hFE0C) == 16'h940C;
        ld_st_direct = (w & 16'hFC0F) == 16'h9000;
        return jmp_call | ld_st_direct;
    endfunction

endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
    import flow_branch_pkg::*;
(
    input  flow_op_e                op,
    input  logic [STAT_W-1:0]       sreg,
    input  logic [SEL_W-1:0]        bit_sel,
    input  logic [7:0]              bit_src,
    input  logic [7:0]              cmp_a,
    input  logic [7:0]              cmp_b,
    output cond_t                   cond
);

    logic              sign_fix;
    logic [STAT_W-1:0] stat_eff;

    // rebuild the sign flag from negative and overflow so a stale bit is ignored
    always_comb begin
        sign_fix = sreg[SIGN_IDX] ^ sreg[NEG_IDX] ^ sreg[OVF_IDX];
        stat_eff = sreg ^ (STAT_W'(sign_fix) << SIGN_IDX);
    end

    always_comb begin
        cond = '0;
        unique case (op)
            OPC_BR_IF_SET: begin
                cond.is_branch = 1'b1;
                cond.hit       = stat_eff[bit_sel];
            end
            OPC_BR_IF_CLR: begin
                cond.is_branch = 1'b1;
                cond.hit       = ~stat_eff[bit_sel];
            end
            OPC_SKIP_IF_CLR: begin
                cond.is_skip = 1'b1;
                cond.hit     = ~bit_src[bit_sel];
            end
            OPC_SKIP_IF_SET: begin
                cond.is_skip = 1'b1;
                cond.hit     = bit_src[bit_sel];
            end
            OPC_SKIP_IF_EQ: begin
                cond.is_skip = 1'b1;
                cond.hit     = (cmp_a == cmp_b);
            end
            default: cond = '0;
        endcase
    end

endmodule

// File: rtl/flow_len_detect.sv
module flow_len_detect
    import flow_branch_pkg::*;
(
    input  logic [INSN_W-1:0] next_opcode,
    output logic              two_word
);

    always_comb two_word = is_long_opcode(next_opcode);

endmodule

// File: rtl/flow_target_calc.sv
module flow_target_calc
    import flow_branch_pkg::*;
#(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFF_W = 7
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  cond_t            cond,
    input  logic             two_word,
    output logic [PC_W-1:0]  next_pc,
    output cyc_t             cycles,
    output logic             taken
);

    localparam int unsigned EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] ofs_ext;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] branch_pc;
    logic [PC_W-1:0] skip_pc;

    always_comb begin
        ofs_ext   = {{EXT_W{offset[OFF_W-1]}}, offset};
        seq_pc    = pc + PC_W'(1);
        branch_pc = seq_pc + ofs_ext;
        skip_pc   = pc + (two_word ? PC_W'(3) : PC_W'(2));
    end

    always_comb begin
        next_pc = seq_pc;
        cycles  = cyc_t'(1);
        taken   = 1'b0;
        if (cond.hit && cond.is_branch) begin
            next_pc = branch_pc;
            cycles  = cyc_t'(2);
            taken   = 1'b1;
        end else if (cond.hit && cond.is_skip) begin
            next_pc = skip_pc;
            cycles  = two_word ? cyc_t'(3) : cyc_t'(2);
            taken   = 1'b1;
        end
    end

endmodule

// File: rtl/flow_branch_unit.sv
module flow_branch_unit
    import flow_branch_pkg::*;
#(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFF_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [PC_W-1:0]   pc,
    input  logic [7:0]        sreg,
    input  logic [OFF_W-1:0]  offset,
    input  logic [2:0]        bit_sel,
    input  logic [7:0]        bit_src,
    input  logic [7:0]        cmp_a,
    input  logic [7:0]        cmp_b,
    input  logic [15:0]       next_opcode,
    output logic              out_valid,
    output logic [PC_W-1:0]   next_pc,
    output logic [1:0]        cycles,
    output logic              taken
);

    flow_op_e        op_dec;
    cond_t           cond;
    logic            two_word;
    logic [PC_W-1:0] pc_d;
    cyc_t            cyc_d;
    logic            taken_d;

    always_comb op_dec = flow_op_e'(req_op);

    flow_cond_eval u_cond (
        .op      (op_dec),
        .sreg    (sreg),
        .bit_sel (bit_sel),
        .bit_src (bit_src),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .cond    (cond)
    );

    flow_len_detect u_len (
        .next_opcode (next_opcode),
        .two_word    (two_word)
    );

    flow_target_calc #(
        .PC_W  (PC_W),
        .OFF_W (OFF_W)
    ) u_tgt (
        .pc       (pc),
        .offset   (offset),
        .cond     (cond),
        .two_word (two_word),
        .next_pc  (pc_d),
        .cycles   (cyc_d),
        .taken    (taken_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            next_pc   <= '0;
            cycles    <= '0;
            taken     <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                next_pc <= pc_d;
                cycles  <= cyc_d;
                taken   <= taken_d;
            end
        end
    end

endmodule

// File: rtl/flow_unit_checker.sv
module flow_unit_checker #(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFF_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [PC_W-1:0]   pc,
    input logic [OFF_W-1:0]  offset,
    input logic              out_valid,
    input logic [PC_W-1:0]   next_pc,
    input logic [1:0]        cycles,
    input logic              taken
);

    localparam int unsigned EXT_W = PC_W - OFF_W;

    assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    assert_idle_no_result_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    assert_taken_branch_target_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op <= 3'd1) |=>
            (!taken || (cycles == 2'd2 &&
             next_pc == $past(pc) + {{EXT_W{$past(offset[OFF_W-1])}}, $past(offset)} + PC_W'(1))));

    assert_sequential_step_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (taken || (cycles == 2'd1 && next_pc == $past(pc) + PC_W'(1))));

    assert_skip_advance_matches_cost_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op inside {3'd2, 3'd3, 3'd4}) |=>
            (!taken || (cycles != 2'd1 && next_pc == $past(pc) + PC_W'(cycles))));

    assert_cost_in_range_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (cycles != 2'd0));

    assert_unused_op_plain_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op > 3'd4) |=> !taken);

endmodule

bind flow_branch_unit flow_unit_checker #(
    .PC_W  (PC_W),
    .OFF_W (OFF_W)
) u_flow_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .pc        (pc),
    .offset    (offset),
    .out_valid (out_valid),
    .next_pc   (next_pc),
    .cycles    (cycles),
    .taken     (taken)
);

// File: tb/flow_branch_unit_bench.sv
`timescale 1ns/1ps
module flow_branch_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [15:0] pc;
    logic [7:0]  sreg;
    logic [6:0]  offset;
    logic [2:0]  bit_sel;
    logic [7:0]  bit_src;
    logic [7:0]  cmp_a;
    logic [7:0]  cmp_b;
    logic [15:0] next_opcode;
    logic        out_valid;
    logic [15:0] next_pc;
    logic [1:0]  cycles;
    logic        taken;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flow_branch_unit u_flow_branch_unit (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_op (req_op),
        .pc (pc), .sreg (sreg), .offset (offset), .bit_sel (bit_sel),
        .bit_src (bit_src), .cmp_a (cmp_a), .cmp_b (cmp_b),
        .next_opcode (next_opcode), .out_valid (out_valid),
        .next_pc (next_pc), .cycles (cycles), .taken (taken)
    );

    function automatic bit long_word(input logic [15:0] w);
        // R10 patterns
        return (w[15:9] == 7'b1001010 && w[3:2] == 2'b11) ||
               (w[15:10] == 6'b100100 && w[3:0] == 4'b0000);
    endfunction

    task automatic compare(input string req, input logic [15:0] e_pc,
                           input logic [1:0] e_cyc, input logic e_tk, input logic e_v);
        checks++;
        if (out_valid !== e_v || next_pc !== e_pc || cycles !== e_cyc || taken !== e_tk) begin
            fails++;
            $display("FAIL %s: actual v=%0b pc=%h cyc=%0d tk=%0b expected v=%0b pc=%h cyc=%0d tk=%0b",
                     req, out_valid, next_pc, cycles, taken, e_v, e_pc, e_cyc, e_tk);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic run_req(input string req, input logic [2:0] op, input logic [15:0] p,
                           input logic [7:0] sr, input logic [6:0] ofs, input logic [2:0] sel,
                           input logic [7:0] src, input logic [7:0] a, input logic [7:0] b,
                           input logic [15:0] nxt);
        logic [7:0]  st;
        logic        hit;
        logic        is_br;
        logic        is_sk;
        logic [15:0] e_pc;
        logic [1:0]  e_cyc;
        req_valid = 1'b1; req_op = op; pc = p; sreg = sr; offset = ofs;
        bit_sel = sel; bit_src = src; cmp_a = a; cmp_b = b; next_opcode = nxt;
        st = sr;
        st[4] = sr[2] ^ sr[3];                       // R4
        is_br = (op <= 3'd1);
        is_sk = (op >= 3'd2 && op <= 3'd4);
        case (op)
            3'd0: hit = st[sel];                     // R3
            3'd1: hit = !st[sel];
            3'd2: hit = !src[sel];                   // R7
            3'd3: hit = src[sel];
            3'd4: hit = (a == b);                    // R8
            default: hit = 1'b0;                     // R12
        endcase
        e_pc = p + 16'd1;
        e_cyc = 2'd1;
        if (hit && is_br) begin                      // R5
            e_pc = p + 16'd1 + {{9{ofs[6]}}, ofs};
            e_cyc = 2'd2;
        end else if (hit && is_sk) begin             // R9
            e_pc = p + (long_word(nxt) ? 16'd3 : 16'd2);
            e_cyc = long_word(nxt) ? 2'd3 : 2'd2;
        end
        @(negedge clk);
        compare(req, e_pc, e_cyc, hit && (is_br || is_sk), 1'b1);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_op = 3'd0; pc = 16'h1234; sreg = 8'hFF;
        offset = 7'd5; bit_sel = 3'd0; bit_src = 8'hFF; cmp_a = 8'd0; cmp_b = 8'd0;
        next_opcode = 16'h940C;
        repeat (3) @(negedge clk);
        compare("R1 during reset", 16'h0000, 2'd0, 1'b0, 1'b0);
        req_valid = 1'b1;
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        compare("R1 after reset release", 16'h0000, 2'd0, 1'b0, 1'b0);
        // R2: result appears only for requests
        run_req("R2 first request", 3'd0, 16'h0100, 8'h01, 7'd3, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0000);
        req_valid = 1'b0; pc = 16'hABCD; req_op = 3'd4;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2 idle: actual out_valid=%0b expected 0", out_valid);
        end

        // R3 R4 R5 R6: every status byte under every bit index, both polarities
        for (int op = 0; op < 2; op++)
            for (int sel = 0; sel < 8; sel++)
                for (int s = 0; s < 256; s++)
                    run_req("R3/R4/R5/R6 branch sweep", 3'(op), 16'(s * 16'h0137 + sel),
                            8'(s), 7'(s * 5 + sel), 3'(sel), 8'h00, 8'h00, 8'h00, 16'h0000);

        // R4 directed: stored sign bit disagrees with N^V
        run_req("R4 ge with stale sign", 3'd1, 16'h0200, 8'h1C, 7'h10, 3'd4, 8'h00, 8'h00, 8'h00, 16'h0);
        run_req("R4 lt with stale sign", 3'd0, 16'h0200, 8'h08, 7'h10, 3'd4, 8'h00, 8'h00, 8'h00, 16'h0);

        // R5 boundaries: extreme offsets and wrap
        run_req("R5 wrap forward", 3'd0, 16'hFFFF, 8'h01, 7'h01, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0);
        run_req("R5 min offset wrap", 3'd0, 16'h0000, 8'h01, 7'h40, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0);
        run_req("R5 max offset", 3'd1, 16'h1000, 8'h00, 7'h3F, 3'd1, 8'h00, 8'h00, 8'h00, 16'h0);
        run_req("R5 offset -1 self loop", 3'd1, 16'h0040, 8'h00, 7'h7F, 3'd1, 8'h00, 8'h00, 8'h00, 16'h0);

        // R7 R9 R11: bit skips over every byte and index, mixed next lengths
        for (int op = 2; op < 4; op++)
            for (int sel = 0; sel < 8; sel++)
                for (int s = 0; s < 256; s++)
                    run_req("R7/R9/R11 bit skip sweep", 3'(op), 16'(s * 16'h0211 + op),
                            8'h00, 7'd0, 3'(sel), 8'(s), 8'h00, 8'h00,
                            ((s + sel) % 3 == 0) ? 16'(16'h940C | (s & 16'h01F3)) :
                            ((s + sel) % 3 == 1) ? 16'(16'h9000 | ((s & 16'h3F) << 4)) :
                            16'(s * 16'h0101));

        // R8: equality skip over an operand grid
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                run_req("R8 compare skip", 3'd4, 16'(a * 16'h0D00 + b), 8'h00, 7'd0, 3'd0, 8'h00,
                        8'(a * 17), 8'((b * 17) ^ ((a == b) ? 0 : 1)), 16'h0000);

        // R10 R9: all opcodes with top nibble 9, then a strided sample of the rest
        for (int w = 16'h9000; w < 16'hA000; w++)
            run_req("R10 length detect", 3'd4, 16'(w), 8'h00, 7'd0, 3'd0, 8'h00,
                    8'h5A, 8'h5A, 16'(w));
        for (int w = 0; w < 65536; w += 17)
            run_req("R10 length detect sample", 3'd4, 16'(w), 8'h00, 7'd0, 3'd0, 8'h00,
                    8'h33, 8'h33, 16'(w));

        // R9 wrap, R11 false skip with long next
        run_req("R9 wrap long skip", 3'd4, 16'hFFFE, 8'h00, 7'd0, 3'd0, 8'h00, 8'h01, 8'h01, 16'h940E);
        run_req("R9 wrap short skip", 3'd3, 16'hFFFF, 8'h00, 7'd0, 3'd7, 8'h80, 8'h00, 8'h00, 16'h0000);
        run_req("R11 false skip long next", 3'd4, 16'h0300, 8'h00, 7'd0, 3'd0, 8'h00, 8'h01, 8'h02, 16'h940C);
        run_req("R11 false bit skip long next", 3'd2, 16'h0300, 8'h00, 7'd0, 3'd5, 8'h20, 8'h00, 8'h00, 16'h9200);

        // R12: unused operation codes with conditions that would otherwise hit
        for (int op = 5; op < 8; op++)
            run_req("R12 unused op", 3'(op), 16'h0400, 8'hFF, 7'h20, 3'd1, 8'hFF, 8'h07, 8'h07, 16'h940C);

        req_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule